// File: doc/BRIEF.md
# Bridge PLL Configuration Word Generator

This block turns a requested per-lane serial bit rate (kbps) and a reference clock frequency (kHz) into the 16-bit PLL setting word of a parallel-to-serial display bridge. It picks a pre-divider, rounds the feedback multiplier up, works out the bit rate that setting actually gives, and from that rate chooses a two-bit frequency band code. One shared restoring divider does all the division in sequence, so each request takes a bounded number of clock cycles.

The same engine also runs the other way. In decode mode the caller supplies a setting word and a reference clock, and the block reports the bit rate that word produces. In compute mode the produced word is decoded the same way. The caller raises `start` for one cycle, waits for the one-cycle `done` pulse, and reads the held results.

Top module: `bridge_pll_cfg_gen`

## Requirements
- R1: In compute mode the pre-divider D is the largest value of at least 1 for which the loop "while refKhz / (D+1) >= 5000, increase D" stops. This equals max(1, floor(refKhz / 5000)) before the clamp of R2.
- R2: D never exceeds 31. A reference of 160000 kHz or more gives D = 31.
- R3: The multiplier M is ceil(rateKbps × D / refKhz). An exact quotient is not rounded up.
- R4: The achieved rate A is floor(refKhz × M / D), using the full M. The band code is 3 when A ≥ 501000, 2 when A ≥ 251000, 1 when A ≥ 126000, and 0 otherwise.
- R5: The compute-mode word has the band code in bits 15:14, 0 in bit 13, D in bits 12:8 and the low 8 bits of M in bits 7:0.
- R6: `decodedRate` is floor(refKhz × m / d). Here m is word bits 7:0 and d is word bits 12:8, and a field equal to zero counts as one. The word is the supplied `wordIn` when `decodeReq` was high at start, and the produced word otherwise. In decode mode `cfgWord` returns `wordIn` unchanged.
- R7: A zero `refKhz` sets `err` to 1 and makes `cfgWord` and `decodedRate` zero in either mode. Any request with a nonzero reference clears `err`.
- R8: `done` is a single-cycle pulse. `busy` is high from the cycle after an accepted start until `done`, and stays under a fixed cycle bound. A `start` while `busy` is high is ignored.
- R9: `cfgWord`, `decodedRate` and `err` change only in the cycle in which `done` is high.
- R10: After reset `busy`, `done` and `err` are 0, and `cfgWord` and `decodedRate` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, accepted when not busy |
| decodeReq | input | 1 | 1: decode `wordIn`; 0: compute a word |
| rateKbps | input | W | Desired per-lane bit rate in kbps |
| refKhz | input | W | Reference clock in kHz |
| wordIn | input | 16 | Setting word to decode in decode mode |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last request had a zero reference |
| cfgWord | output | 16 | Produced or echoed setting word |
| decodedRate | output | W+8 | Bit rate the word yields, kbps |

## Verification
The bench drives the three band thresholds exactly. A design that compares with ">" instead of ">=" would drop to the band below. It uses quotients that divide exactly, where a design that always adds one to the multiplier would give a rate that is too high. It uses references large enough to hit the divider clamp, where a missing clamp would spill into the band field. A multiplier above 255 shows whether the band comes from the full multiplier while the decoded rate uses only the truncated field. Zero fields in decode mode expose a divide by zero or a zero rate. A start pulse sent during a busy request would corrupt the result if the design failed to ignore it.

// File: rtl/bridge_pll_pkg.sv
package bridge_pll_pkg;
  localparam int MIN_INTER_KHZ = 5000;
  localparam int DIV_MAX       = 31;
  localparam int DIV_W         = 5;
  localparam int MUL_FIELD_W   = 8;
  localparam int BAND3_MIN     = 501000;
  localparam int BAND2_MIN     = 251000;
  localparam int BAND1_MIN     = 126000;

  typedef enum logic [1:0] {OP_MUL, OP_RATE, OP_DEC} opSel_e;

  typedef struct packed {
    logic   load;
    logic   divInc;
    logic   divGo;
    opSel_e op;
    logic   capMul;
    logic   capRate;
    logic   capDec;
    logic   publish;
  } ctrlStrobe_t;
endpackage

// File: rtl/bridge_pll_divider.sv
module bridge_pll_divider #(
  parameter int NUM_W = 41,
  parameter int DEN_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             go,
  input  logic [NUM_W-1:0] dividend,
  input  logic [DEN_W-1:0] divisor,
  output logic [NUM_W-1:0] quotient,
  output logic             finished
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [DEN_W-1:0] remQ, denQ;
  logic [NUM_W-1:0] quoQ;
  logic [CNT_W-1:0] cntQ;
  logic             runQ;
  logic [DEN_W:0]   trial, diff;
  logic             fits;

  always_comb begin
    trial = {remQ, quoQ[NUM_W-1]};
    diff  = trial - {1'b0, denQ};
    fits  = trial >= {1'b0, denQ};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remQ <= '0; denQ <= '1; quoQ <= '0; cntQ <= '0; runQ <= 1'b0; finished <= 1'b0;
    end else begin
      finished <= 1'b0;
      if (go) begin
        remQ <= '0;
        denQ <= divisor;
        quoQ <= dividend;
        cntQ <= CNT_W'(NUM_W);
        runQ <= 1'b1;
      end else if (runQ) begin
        remQ <= fits ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
        quoQ <= {quoQ[NUM_W-2:0], fits};
        cntQ <= cntQ - 1'b1;
        if (cntQ == CNT_W'(1)) begin
          runQ     <= 1'b0;
          finished <= 1'b1;
        end
      end
    end
  end

  assign quotient = quoQ;

  // R3: a finished division leaves a remainder below the divisor
  assert_rem_below_den_R3: assert property (@(posedge clk) disable iff (!rstN)
    finished |-> (remQ < denQ));
endmodule

// File: rtl/bridge_pll_dp.sv
module bridge_pll_dp
  import bridge_pll_pkg::*;
#(
  parameter int W = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrlStrobe_t   ctl,
  input  logic          modeIn,
  input  logic [W-1:0]  rateIn,
  input  logic [W-1:0]  refIn,
  input  logic [15:0]   wordIn,
  output logic          canGrow,
  output logic          refZero,
  output logic          decodeMode,
  output logic          divFinished,
  output logic [15:0]   cfgWord,
  output logic [W+7:0]  decodedRate,
  output logic          errFlag
);
  localparam int NUM_W = W + 9;
  localparam int CMP_W = W + 4;

  logic [W-1:0]       rateQ, refQ;
  logic [15:0]        wordQ, cfgQ;
  logic [DIV_W-1:0]   divQ, decDiv;
  logic [NUM_W-1:0]   mulQ, dividend, quotient;
  logic [W-1:0]       divisor;
  logic [1:0]         bandQ;
  logic [W+7:0]       decRateQ, rateOutQ;
  logic [MUL_FIELD_W-1:0] decMul;
  logic [CMP_W-1:0]   need;
  logic               modeQ, errQ;

  always_comb begin
    need    = CMP_W'(MIN_INTER_KHZ) * (CMP_W'(divQ) + CMP_W'(1));
    canGrow = (divQ < DIV_W'(DIV_MAX)) && (CMP_W'(refQ) >= need);
    refZero = (refQ == '0);
    decMul  = modeQ ? wordQ[7:0]  : mulQ[MUL_FIELD_W-1:0];
    decDiv  = modeQ ? wordQ[12:8] : divQ;
    if (decMul == '0) decMul = MUL_FIELD_W'(1);
    if (decDiv == '0) decDiv = DIV_W'(1);
    unique case (ctl.op)
      OP_MUL: begin
        dividend = NUM_W'(rateQ) * NUM_W'(divQ) + NUM_W'(refQ) - NUM_W'(1);
        divisor  = refQ;
      end
      OP_RATE: begin
        dividend = NUM_W'(refQ) * mulQ;
        divisor  = W'(divQ);
      end
      default: begin
        dividend = NUM_W'(refQ) * NUM_W'(decMul);
        divisor  = W'(decDiv);
      end
    endcase
  end

  bridge_pll_divider #(.NUM_W(NUM_W), .DEN_W(W)) uDiv (
    .clk(clk), .rstN(rstN), .go(ctl.divGo), .dividend(dividend),
    .divisor(divisor), .quotient(quotient), .finished(divFinished));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rateQ <= '0; refQ <= '0; wordQ <= '0; modeQ <= 1'b0; divQ <= DIV_W'(1);
      mulQ <= '0; bandQ <= '0; decRateQ <= '0;
      cfgQ <= '0; rateOutQ <= '0; errQ <= 1'b0;
    end else begin
      if (ctl.load) begin
        rateQ <= rateIn; refQ <= refIn; wordQ <= wordIn; modeQ <= modeIn;
        divQ  <= DIV_W'(1);
      end
      if (ctl.divInc)  divQ <= divQ + 1'b1;
      if (ctl.capMul)  mulQ <= quotient;
      if (ctl.capRate) begin
        if      (quotient >= NUM_W'(BAND3_MIN)) bandQ <= 2'd3;
        else if (quotient >= NUM_W'(BAND2_MIN)) bandQ <= 2'd2;
        else if (quotient >= NUM_W'(BAND1_MIN)) bandQ <= 2'd1;
        else                                    bandQ <= 2'd0;
      end
      if (ctl.capDec) decRateQ <= quotient[W+7:0];
      if (ctl.publish) begin
        if (refZero) begin
          errQ <= 1'b1; cfgQ <= '0; rateOutQ <= '0;
        end else begin
          errQ     <= 1'b0;
          rateOutQ <= decRateQ;
          cfgQ     <= modeQ ? wordQ : {bandQ, 1'b0, divQ, mulQ[MUL_FIELD_W-1:0]};
        end
      end
    end
  end

  assign decodeMode  = modeQ;
  assign cfgWord     = cfgQ;
  assign decodedRate = rateOutQ;
  assign errFlag     = errQ;

  assert_div_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    (divQ >= DIV_W'(1)) && (divQ <= DIV_W'(DIV_MAX)));
  assert_err_zero_out_R7: assert property (@(posedge clk) disable iff (!rstN)
    errQ |-> (cfgQ == '0) && (rateOutQ == '0));
  assert_hold_outputs_R9: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.publish |=> $stable(cfgQ) && $stable(rateOutQ) && $stable(errQ));
endmodule

// File: rtl/bridge_pll_ctrl.sv
module bridge_pll_ctrl
  import bridge_pll_pkg::*;
#(
  parameter int LIMIT = 200
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        canGrow,
  input  logic        refZero,
  input  logic        decodeMode,
  input  logic        divFinished,
  output ctrlStrobe_t ctl,
  output logic        busy,
  output logic        done
);
  typedef enum logic [3:0] {
    S_IDLE, S_CHECK, S_SEARCH, S_MUL_GO, S_MUL_WAIT,
    S_RATE_GO, S_RATE_WAIT, S_DEC_GO, S_DEC_WAIT, S_FIN
  } state_e;

  localparam int BC_W = $clog2(LIMIT + 2);

  state_e stateQ, stateD;
  logic [BC_W-1:0] busyCnt;

  always_comb begin
    stateD = stateQ;
    ctl    = '0;
    ctl.op = OP_DEC;
    unique case (stateQ)
      S_IDLE:   if (start) begin ctl.load = 1'b1; stateD = S_CHECK; end
      S_CHECK:  stateD = refZero ? S_FIN : (decodeMode ? S_DEC_GO : S_SEARCH);
      S_SEARCH: if (canGrow) ctl.divInc = 1'b1; else stateD = S_MUL_GO;
      S_MUL_GO:  begin ctl.op = OP_MUL; ctl.divGo = 1'b1; stateD = S_MUL_WAIT; end
      S_MUL_WAIT: if (divFinished) begin ctl.capMul = 1'b1; stateD = S_RATE_GO; end
      S_RATE_GO: begin ctl.op = OP_RATE; ctl.divGo = 1'b1; stateD = S_RATE_WAIT; end
      S_RATE_WAIT: if (divFinished) begin ctl.capRate = 1'b1; stateD = S_DEC_GO; end
      S_DEC_GO:  begin ctl.divGo = 1'b1; stateD = S_DEC_WAIT; end
      S_DEC_WAIT: if (divFinished) begin ctl.capDec = 1'b1; stateD = S_FIN; end
      S_FIN:     begin ctl.publish = 1'b1; stateD = S_IDLE; end
      default:   stateD = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= S_IDLE; done <= 1'b0; busyCnt <= '0;
    end else begin
      stateQ  <= stateD;
      done    <= (stateQ == S_FIN);
      busyCnt <= (stateD == S_IDLE) ? '0 : busyCnt + 1'b1;
    end
  end

  assign busy = (stateQ != S_IDLE);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  assert_busy_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (busyCnt < BC_W'(LIMIT)));
  assert_done_ends_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy && $past(busy));
endmodule

// File: rtl/bridge_pll_cfg_gen.sv
module bridge_pll_cfg_gen
  import bridge_pll_pkg::*;
#(
  parameter int W = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          decodeReq,
  input  logic [W-1:0]  rateKbps,
  input  logic [W-1:0]  refKhz,
  input  logic [15:0]   wordIn,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [15:0]   cfgWord,
  output logic [W+7:0]  decodedRate
);
  localparam int LIMIT = DIV_MAX + 3 * (W + 9 + 3) + 8;

  ctrlStrobe_t ctl;
  logic canGrow, refZero, decodeMode, divFinished;

  bridge_pll_ctrl #(.LIMIT(LIMIT)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .canGrow(canGrow),
    .refZero(refZero), .decodeMode(decodeMode), .divFinished(divFinished),
    .ctl(ctl), .busy(busy), .done(done));

  bridge_pll_dp #(.W(W)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .modeIn(decodeReq), .rateIn(rateKbps),
    .refIn(refKhz), .wordIn(wordIn), .canGrow(canGrow), .refZero(refZero),
    .decodeMode(decodeMode), .divFinished(divFinished), .cfgWord(cfgWord),
    .decodedRate(decodedRate), .errFlag(err));
endmodule

// File: tb/sim_bridge_pll_cfg_gen.sv
`timescale 1ns/1ps
module sim_bridge_pll_cfg_gen;
  localparam int W = 32;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0, decodeReq = 1'b0;
  logic [W-1:0] rateKbps = '0, refKhz = '0;
  logic [15:0] wordIn = '0;
  logic busy, done, err;
  logic [15:0] cfgWord;
  logic [W+7:0] decodedRate;

  int checks = 0, errors = 0;
  logic [15:0]  heldWord = '0;
  logic [W+7:0] heldRate = '0;
  logic         heldErr  = 1'b0;

  always #2.5 clk = ~clk;

  bridge_pll_cfg_gen #(.W(W)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .decodeReq(decodeReq),
    .rateKbps(rateKbps), .refKhz(refKhz), .wordIn(wordIn), .busy(busy),
    .done(done), .err(err), .cfgWord(cfgWord), .decodedRate(decodedRate));

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] decodeOf(input logic [127:0] ref_, input logic [15:0] w);
    logic [127:0] m, d;
    m = w[7:0];  if (m == 0) m = 1;
    d = w[12:8]; if (d == 0) d = 1;
    return ref_ * m / d;
  endfunction

  task automatic model(input bit dec, input logic [127:0] rate, input logic [127:0] ref_,
                       input logic [15:0] win, output logic [15:0] ew,
                       output logic [127:0] er, output bit ee);
    logic [127:0] d, mul, ach;
    logic [1:0] band;
    ee = (ref_ == 0);
    if (ee) begin ew = 0; er = 0; return; end
    if (dec) begin ew = win; er = decodeOf(ref_, win); return; end
    d = ref_ / 5000;
    if (d < 1) d = 1;
    if (d > 31) d = 31;
    mul = (rate * d + ref_ - 1) / ref_;
    ach = ref_ * mul / d;
    band = (ach >= 501000) ? 2'd3 : (ach >= 251000) ? 2'd2 : (ach >= 126000) ? 2'd1 : 2'd0;
    ew = {band, 1'b0, d[4:0], mul[7:0]};
    er = decodeOf(ref_, ew);
  endtask

  // poke: send a different start while busy (must be ignored)
  task automatic run(input bit dec, input logic [W-1:0] rate, input logic [W-1:0] ref_,
                     input logic [15:0] win, input bit poke, input string tag);
    logic [15:0] ew; logic [127:0] er; bit ee; int n;
    model(dec, rate, ref_, win, ew, er, ee);
    @(negedge clk);
    decodeReq = dec; rateKbps = rate; refKhz = ref_; wordIn = win; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, {tag, " R8 busy after start"}, busy, 1);
    n = 0;
    while (done !== 1'b1 && n < 2000) begin
      if (poke && n == 3) begin
        decodeReq = 1'b0; rateKbps = 32'd999999; refKhz = 32'd12345; wordIn = 16'hFFFF; start = 1'b1;
      end else start = 1'b0;
      if (cfgWord !== heldWord || decodedRate !== heldRate || err !== heldErr) begin
        check(1'b0, {tag, " R9 outputs moved while busy"}, cfgWord, heldWord);
      end
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    check(done === 1'b1, {tag, " R8 done within bound"}, n, 2000);
    check(cfgWord === ew, {tag, " R5 word"}, cfgWord, ew);
    check(decodedRate === er[W+7:0], {tag, " R6 decoded rate"}, decodedRate, er[63:0]);
    check(err === ee, {tag, " R7 err"}, err, ee);
    heldWord = cfgWord; heldRate = decodedRate; heldErr = err;
    @(negedge clk);
    check(done === 1'b0 && busy === 1'b0, {tag, " R8 done single pulse"}, {done, busy}, 0);
    check(cfgWord === heldWord && decodedRate === heldRate, {tag, " R9 outputs held"}, cfgWord, heldWord);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog R8 actual=hung expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy === 0 && done === 0 && err === 0, "R10 reset flags", {busy, done, err}, 0);
    check(cfgWord === 0 && decodedRate === 0, "R10 reset outputs", cfgWord, 0);
    rstN = 1'b1;
    @(negedge clk);
    // R1 / R3 / R4 typical: D=5, M=89, band 2
    run(1'b0, 32'd480000, 32'd27000, 16'h0, 1'b0, "R1 typical");
    check(cfgWord[12:8] === 5'd5, "R1 divider field", cfgWord[12:8], 5);
    check(cfgWord[7:0] === 8'd89, "R3 rounded-up multiplier", cfgWord[7:0], 89);
    check(cfgWord[15:14] === 2'd2, "R4 band mid", cfgWord[15:14], 2);
    // R1 small reference keeps D=1
    run(1'b0, 32'd100000, 32'd4000, 16'h0, 1'b0, "R1 small ref");
    check(cfgWord[12:8] === 5'd1, "R1 minimum divider", cfgWord[12:8], 1);
    // R2 clamp
    run(1'b0, 32'd1000000, 32'd200000, 16'h0, 1'b0, "R2 clamp");
    check(cfgWord[12:8] === 5'd31 && cfgWord[13] === 1'b0, "R2 clamp field", cfgWord[13:8], 31);
    // R3 exact quotient: D=2, M=10
    run(1'b0, 32'd50000, 32'd10000, 16'h0, 1'b0, "R3 exact");
    check(cfgWord[7:0] === 8'd10, "R3 no extra round-up", cfgWord[7:0], 10);
    // R4 thresholds exactly on and just below
    run(1'b0, 32'd126000, 32'd6000, 16'h0, 1'b0, "R4 band1 edge");
    check(cfgWord[15:14] === 2'd1, "R4 band 1 at 126000", cfgWord[15:14], 1);
    run(1'b0, 32'd120000, 32'd6000, 16'h0, 1'b0, "R4 band0");
    check(cfgWord[15:14] === 2'd0, "R4 band 0", cfgWord[15:14], 0);
    run(1'b0, 32'd251000, 32'd1000, 16'h0, 1'b0, "R4 band2 edge");
    check(cfgWord[15:14] === 2'd2, "R4 band 2 at 251000", cfgWord[15:14], 2);
    run(1'b0, 32'd250000, 32'd1000, 16'h0, 1'b0, "R4 band1 below");
    check(cfgWord[15:14] === 2'd1, "R4 band 1 below 251000", cfgWord[15:14], 1);
    // R4/R5 multiplier 501 > 255: band from full M, field truncated
    run(1'b0, 32'd501000, 32'd1000, 16'h0, 1'b0, "R5 wide mul");
    check(cfgWord[15:14] === 2'd3 && cfgWord[7:0] === 8'd245, "R5 truncated field band 3", cfgWord, 16'hC1F5);
    check(decodedRate === 40'd245000, "R6 decode of truncated word", decodedRate, 245000);
    // R7 zero reference, then recovery
    run(1'b0, 32'd480000, 32'd0, 16'h0, 1'b0, "R7 zero ref");
    check(err === 1'b1, "R7 err set", err, 1);
    run(1'b1, 32'd0, 32'd0, 16'h0A05, 1'b0, "R7 zero ref decode");
    // R6 decode mode with zero fields
    run(1'b1, 32'd0, 32'd24000, 16'h0000, 1'b0, "R6 both zero");
    check(err === 1'b0 && decodedRate === 40'd24000, "R7 err cleared R6 zero fields", decodedRate, 24000);
    run(1'b1, 32'd0, 32'd24000, 16'h000A, 1'b0, "R6 div zero");
    run(1'b1, 32'd0, 32'd27000, 16'h8559, 1'b0, "R6 normal decode");
    // R8 start during busy ignored
    run(1'b0, 32'd330000, 32'd19200, 16'h0, 1'b1, "R8 ignore start");
    run(1'b0, 32'd700000, 32'd38400, 16'h0, 1'b0, "R1 mixed");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule